// File: doc/BRIEF.md
# UART FIFO status and interrupt logic

This block holds the receive and transmit byte queues of a UART-style peripheral and turns their fill levels into status flags and interrupt sources. The line side pushes received bytes into the receive queue and drains bytes from the transmit queue. The host side pops received bytes with a read strobe and queues bytes for transmission with a write strobe. Serial framing, baud generation and register decoding are outside the block. Only simple strobes and a one-bit-period tick reach it.

The receive and transmit interrupts fire at a half-depth watermark, not when a queue is completely full or empty. This lets software move a burst of bytes per interrupt. Small amounts of waiting receive data would otherwise sit below the watermark. A receive-timeout interrupt reports them: it fires when data waits and the line has been quiet for a fixed number of bit periods.

Each raw interrupt bit is gated by a mask bit. The gated bits are ORed into one active-high interrupt line.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset both queues are empty, `rx_empty` and `tx_empty` are 1, `rx_full`, `tx_full`, `tx_busy` and `tx_overflow` are 0, the mask is 0, `irq` is 0 and `raw_irq` equals 3'b010 (only the transmit interrupt).
- R2: The receive interrupt, `raw_irq[0]`, is 1 exactly while the receive level is 16 or more (half of the 32-entry depth). It drops right after a host read leaves 15 or fewer bytes.
- R3: The transmit interrupt, `raw_irq[1]`, is 1 exactly while the transmit level is 16 or less. It is re-evaluated after every host write and every line drain.
- R4: The receive-timeout interrupt, `raw_irq[2]`, becomes 1 on the 32nd `baud_tick` after the most recent accepted receive push or pop, provided the receive queue is not empty. It stays 1 until the receive queue becomes empty, and it is 0 in the same cycle the queue empties.
- R5: `rx_empty` is 1 exactly when the receive level is 0. `rx_full` is 1 exactly when the receive level is 32, so any host read of a full queue clears it.
- R6: `tx_full` and `tx_busy` become 1 when a host write brings the transmit level to 32. Both return to 0 as soon as the line side drains one byte.
- R7: `tx_empty` is 0 after any host write and returns to 1 when the line side drains the last byte.
- R8: A host write to a full transmit queue is discarded. It raises `tx_overflow` for exactly one cycle and leaves the level and data unchanged. A line push into a full receive queue is dropped. A host read of an empty receive queue pops nothing, and `host_rd_data` reads 8'h00 while the queue is empty.
- R9: `masked_irq` is `raw_irq` ANDed with the mask written through `irq_mask_we`. `irq` is the OR of the `masked_irq` bits.
- R10: A push and a pop of the same non-empty, non-full queue in one cycle leave its level unchanged. Flags and interrupts follow the unchanged level.
- R11: Both queues deliver bytes in first-in, first-out order. `host_rd_data` and `line_tx_data` present the oldest byte before it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_rx_valid | input | 1 | Push strobe for a received byte |
| line_rx_data | input | 8 | Received byte |
| line_tx_ready | input | 1 | Drain strobe for the transmit queue |
| line_tx_valid | output | 1 | Transmit queue holds a byte |
| line_tx_data | output | 8 | Oldest transmit byte |
| host_rd | input | 1 | Host read strobe (pops the receive queue) |
| host_rd_data | output | 8 | Oldest received byte, 0 when empty |
| host_wr | input | 1 | Host write strobe (pushes the transmit queue) |
| host_wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One pulse per bit period |
| irq_mask_we | input | 1 | Mask write strobe |
| irq_mask_wdata | input | 3 | New mask value |
| irq_mask | output | 3 | Current mask |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_busy | output | 1 | Transmit side busy (queue filled) |
| tx_overflow | output | 1 | One-cycle pulse after a discarded host write |
| raw_irq | output | 3 | Raw status: bit 0 receive, bit 1 transmit, bit 2 receive timeout |
| masked_irq | output | 3 | Raw status ANDed with mask |
| irq | output | 1 | Combined interrupt line |

## Verification
Every strobe takes effect at the rising edge it is sampled on. Levels, flags, raw and masked interrupts and the overflow pulse are therefore due right after that same edge, with no extra pipeline cycle. The receive timeout is due right after the edge that samples the 32nd tick. The bench applies each strobe for one cycle from a falling edge and samples at the next falling edge. It reads data outputs before the pop that consumes them. For the timeout it checks one tick early that the bit is still clear, then checks that it has risen on the 32nd tick.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
   localparam int IRQ_RX  = 0;
   localparam int IRQ_TX  = 1;
   localparam int IRQ_RT  = 2;
   localparam int NUM_IRQ = 3;
endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("byte_queue: DEPTH must be a power of two of at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("byte_queue: WIDTH must be positive");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign full    = (count == DEPTH_C);
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R5
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C);
   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(count));
   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> $stable(count));
   // R10
   push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !full && !empty) |=> $stable(count));
endmodule

// File: rtl/rx_quiet_timer.sv
module rx_quiet_timer #(
   parameter int LIMIT = 32,
   localparam int TW = $clog2(LIMIT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic active,
   output logic expire
);
   localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("rx_quiet_timer: LIMIT must be at least 2");
   end

   logic [TW-1:0] ticks;

   assign expire = tick && active && !restart && (ticks == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)                 ticks <= '0;
      else if (restart || !active) ticks <= '0;
      else if (tick && ticks != LAST) ticks <= ticks + 1'b1;
   end

   // R4
   quiet_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expire || (ticks == LAST && $past(LIMIT == 2)));
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
   import uart_fifo_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 32,
   parameter int TRIG       = DEPTH / 2,
   parameter int QUIET_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_rx_valid,
   input  logic [DATA_W-1:0] line_rx_data,
   input  logic              line_tx_ready,
   output logic              line_tx_valid,
   output logic [DATA_W-1:0] line_tx_data,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              baud_tick,
   input  logic              irq_mask_we,
   input  logic [NUM_IRQ-1:0] irq_mask_wdata,
   output logic [NUM_IRQ-1:0] irq_mask,
   output logic              rx_empty,
   output logic              rx_full,
   output logic              tx_empty,
   output logic              tx_full,
   output logic              tx_busy,
   output logic              tx_overflow,
   output logic [NUM_IRQ-1:0] raw_irq,
   output logic [NUM_IRQ-1:0] masked_irq,
   output logic              irq
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] RX_MARK = CW'(TRIG);
   localparam logic [CW-1:0] TX_MARK = CW'(DEPTH - TRIG);

   if (TRIG < 1 || TRIG > DEPTH) begin : g_bad_trig
      $error("uart_fifo_irq: TRIG must lie in 1..DEPTH");
   end

   logic [CW-1:0] rx_level, tx_level;
   logic [DATA_W-1:0] rx_head;
   logic rx_push_ok, rx_pop_ok, quiet_expire, rt_q;

   byte_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(line_rx_valid), .push_data(line_rx_data),
      .pop(host_rd), .head(rx_head), .count(rx_level),
      .full(rx_full), .empty(rx_empty)
   );

   byte_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(host_wr), .push_data(host_wr_data),
      .pop(line_tx_ready), .head(line_tx_data), .count(tx_level),
      .full(tx_full), .empty(tx_empty)
   );

   assign rx_push_ok    = line_rx_valid && !rx_full;
   assign rx_pop_ok     = host_rd && !rx_empty;
   assign host_rd_data  = rx_empty ? '0 : rx_head;
   assign line_tx_valid = !tx_empty;
   assign tx_busy       = tx_full;

   rx_quiet_timer #(.LIMIT(QUIET_BITS)) u_quiet (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick),
      .restart(rx_push_ok || rx_pop_ok), .active(!rx_empty),
      .expire(quiet_expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rt_q        <= 1'b0;
         tx_overflow <= 1'b0;
         irq_mask    <= '0;
      end else begin
         rt_q        <= !rx_empty && (rt_q || quiet_expire);
         tx_overflow <= host_wr && tx_full;
         if (irq_mask_we) irq_mask <= irq_mask_wdata;
      end
   end

   assign raw_irq[IRQ_RX] = (rx_level >= RX_MARK);
   assign raw_irq[IRQ_TX] = (tx_level <= TX_MARK);
   assign raw_irq[IRQ_RT] = rt_q && !rx_empty;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
      assign masked_irq[i] = raw_irq[i] && irq_mask[i];
   end
   assign irq = |masked_irq;

   // R8
   wr_discard_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && tx_full) |=> tx_overflow);
   // R4
   rt_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_irq[IRQ_RT]) |-> $past(baud_tick));
   // R4
   rt_not_on_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_empty) |-> !raw_irq[IRQ_RT]);
   // R3
   tx_idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> raw_irq[IRQ_TX]);
   // R6
   full_clears_on_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && line_tx_ready && !host_wr) |=> !tx_full && !tx_busy);
endmodule

// File: tb/sim_uart_fifo_irq.sv
`timescale 1ns/1ps
module sim_uart_fifo_irq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_rx_valid = 1'b0, line_tx_ready = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic baud_tick = 1'b0, irq_mask_we = 1'b0;
   logic [7:0] line_rx_data = '0, host_wr_data = '0;
   logic [2:0] irq_mask_wdata = '0;
   logic line_tx_valid, rx_empty, rx_full, tx_empty, tx_full, tx_busy, tx_overflow, irq;
   logic [7:0] line_tx_data, host_rd_data;
   logic [2:0] irq_mask, raw_irq, masked_irq;

   int tests = 0;
   int fails = 0;
   logic [7:0] rx_wseq = 8'h10, rx_rseq = 8'h10, tx_wseq = 8'h80, tx_rseq = 8'h80;

   always #2.5 clk = ~clk;

   uart_fifo_irq u0 (
      .clk(clk), .rst_n(rst_n),
      .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
      .line_tx_ready(line_tx_ready), .line_tx_valid(line_tx_valid),
      .line_tx_data(line_tx_data), .host_rd(host_rd), .host_rd_data(host_rd_data),
      .host_wr(host_wr), .host_wr_data(host_wr_data), .baud_tick(baud_tick),
      .irq_mask_we(irq_mask_we), .irq_mask_wdata(irq_mask_wdata), .irq_mask(irq_mask),
      .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full),
      .tx_busy(tx_busy), .tx_overflow(tx_overflow), .raw_irq(raw_irq),
      .masked_irq(masked_irq), .irq(irq)
   );

   // ops: 0 line push, 1 host read, 2 host write, 3 line drain
   // fields: op[15:14] repeat[13:8] raw[7:5] flags{rx_empty,rx_full,tx_empty,tx_full,busy}[4:0]
   localparam logic [15:0] VEC [13] = '{
      {2'd0, 6'd15, 3'b010, 5'b00100},
      {2'd0, 6'd1,  3'b011, 5'b00100},
      {2'd0, 6'd16, 3'b011, 5'b01100},
      {2'd1, 6'd1,  3'b011, 5'b00100},
      {2'd1, 6'd15, 3'b011, 5'b00100},
      {2'd1, 6'd1,  3'b010, 5'b00100},
      {2'd1, 6'd15, 3'b010, 5'b10100},
      {2'd2, 6'd16, 3'b010, 5'b10000},
      {2'd2, 6'd1,  3'b000, 5'b10000},
      {2'd2, 6'd15, 3'b000, 5'b10011},
      {2'd3, 6'd1,  3'b000, 5'b10000},
      {2'd3, 6'd15, 3'b010, 5'b10000},
      {2'd3, 6'd16, 3'b010, 5'b10100}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] flags();
      return {rx_empty, rx_full, tx_empty, tx_full, tx_busy};
   endfunction

   task automatic cycle();
      @(negedge clk);
      line_rx_valid = 0; host_rd = 0; host_wr = 0; line_tx_ready = 0;
      baud_tick = 0; irq_mask_we = 0;
   endtask

   task automatic do_op(input int kind);
      case (kind)
         0: begin line_rx_valid = 1; line_rx_data = rx_wseq; rx_wseq++; end
         1: begin check("R11 rx order", host_rd_data, rx_rseq); rx_rseq++; host_rd = 1; end
         2: begin host_wr = 1; host_wr_data = tx_wseq; tx_wseq++; end
         default: begin check("R11 tx order", line_tx_data, tx_rseq); tx_rseq++; line_tx_ready = 1; end
      endcase
      cycle();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin baud_tick = 1; cycle(); end
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 flags", flags(), 5'b10100);
      check("R1 raw", raw_irq, 3'b010);
      check("R1 irq", {irq_mask, irq, tx_overflow}, 0);

      for (int v = 0; v < 13; v++) begin
         for (int k = 0; k < int'(VEC[v][13:8]); k++) do_op(int'(VEC[v][15:14]));
         check("R2/R3 raw after vector", raw_irq, VEC[v][7:5]);
         check("R5/R6/R7 flags after vector", flags(), VEC[v][4:0]);
      end

      // R4 timeout fires on the 32nd tick
      do_op(0);
      ticks(31);
      check("R4 rt before 32nd tick", raw_irq[2], 1'b0);
      ticks(1);
      check("R4 rt on 32nd tick", raw_irq[2], 1'b1);
      do_op(0);
      check("R4 rt stays while data", raw_irq[2], 1'b1);
      do_op(1);
      check("R4 rt stays after partial read", raw_irq[2], 1'b1);
      do_op(1);
      check("R4 rt clears on empty", raw_irq[2], 1'b0);
      // R4 restart on push
      do_op(0); ticks(20); do_op(0); ticks(20);
      check("R4 restart on push", raw_irq[2], 1'b0);
      ticks(11);
      check("R4 restart 31 ticks", raw_irq[2], 1'b0);
      ticks(1);
      check("R4 restart 32 ticks", raw_irq[2], 1'b1);
      do_op(1); do_op(1);

      // R8 write to full transmit queue
      for (int k = 0; k < 32; k++) do_op(2);
      host_wr = 1; host_wr_data = 8'hEE; cycle();
      check("R8 overflow pulse", tx_overflow, 1'b1);
      check("R8 still full", tx_full, 1'b1);
      cycle();
      check("R8 overflow one cycle", tx_overflow, 1'b0);
      for (int k = 0; k < 32; k++) do_op(3);
      check("R8 tx empty after 32 drains", tx_empty, 1'b1);

      // R8 read of empty receive queue
      check("R8 empty read data", host_rd_data, 8'h00);
      host_rd = 1; cycle();
      check("R8 empty read no pop", rx_empty, 1'b1);
      do_op(0); do_op(1);
      check("R8 rx empty after one in one out", rx_empty, 1'b1);
      // R8 line push into full receive queue
      for (int k = 0; k < 32; k++) do_op(0);
      line_rx_valid = 1; line_rx_data = 8'hEE; cycle();
      for (int k = 0; k < 32; k++) do_op(1);
      check("R8 dropped rx byte", rx_empty, 1'b1);

      // R10 simultaneous push and pop
      for (int k = 0; k < 16; k++) do_op(0);
      check("R10 rx data", host_rd_data, rx_rseq);
      rx_rseq++; host_rd = 1;
      line_rx_valid = 1; line_rx_data = rx_wseq; rx_wseq++;
      cycle();
      check("R10 rx level held at 16", raw_irq[0], 1'b1);
      do_op(1);
      check("R10 rx level was 16", raw_irq[0], 1'b0);
      for (int k = 0; k < 15; k++) do_op(1);
      for (int k = 0; k < 16; k++) do_op(2);
      check("R10 tx data", line_tx_data, tx_rseq);
      tx_rseq++; line_tx_ready = 1;
      host_wr = 1; host_wr_data = tx_wseq; tx_wseq++;
      cycle();
      check("R10 tx level held at 16", raw_irq[1], 1'b1);
      do_op(2);
      check("R10 tx level was 16", raw_irq[1], 1'b0);
      for (int k = 0; k < 17; k++) do_op(3);

      // R9 masking
      irq_mask_we = 1; irq_mask_wdata = 3'b010; cycle();
      check("R9 masked tx", {masked_irq, irq}, {3'b010, 1'b1});
      irq_mask_we = 1; irq_mask_wdata = 3'b101; cycle();
      check("R9 masked off", {masked_irq, irq}, {3'b000, 1'b0});
      for (int k = 0; k < 16; k++) do_op(0);
      check("R9 rx through mask", {masked_irq, irq}, {3'b001, 1'b1});

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule